// File: doc/BRIEF.md
# Channel Group Teardown Sequencer

This block removes one channel group from service so that it can be recovered after a fault or a hang. A single start pulse carries the runlist number and the group ID. The block then works through a fixed order of steps:

1. It turns scheduling off for that runlist.
2. It disables the group's channels.
3. It requests a preempt, without waiting on that request.
4. It watches the status of every PBDMA and every engine that serves the runlist.
5. It resets each engine that is still holding the group's context.
6. It turns scheduling back on.

Interrupt service and engine-specific reinitialisation are outside the block. Both are reached through request/acknowledge handshakes.

The reset decision for each engine is made from that engine's context-switch state. The state is compared against the current owner ID or the incoming ID, depending on its value. An engine that keeps holding a matching context until a programmable poll limit runs out is reset instead of being waited on for ever. When the sequence ends, a one-cycle done pulse is issued together with a bit vector of the engines that were reset.

Top module: `tds_seq`

## Requirements
- R1: After an accepted start, the one-cycle pulses `sched_dis_o`, `chan_dis_o` and `preempt_o` appear on three consecutive cycles in that order. The latched runlist is on `sched_rl_o` and the latched group on `target_gid_o`.
- R2: No interrupt service request, engine halt or engine reset is raised in a run before that run's preempt pulse.
- R3: Scheduling is not re-enabled until every PBDMA marked in `pbdma_serves_i` shows `pbdma_busy_i` low with no interrupt outstanding. PBDMAs that are not marked are ignored.
- R4: While polling, a served PBDMA with `pbdma_intr_i` high gets `intr_svc_req_o` for that PBDMA. The request is held until `intr_svc_ack_i` is seen.
- R5: Engine status codes are 3 bits wide: 0 INVALID, 1 VALID, 2 SAVE, 3 LOAD, 4 SWITCH, with 5 to 7 treated like SWITCH. SWITCH keeps the engine under polling with no decision made.
- R6: An engine whose status reads INVALID is never reset.
- R7: For VALID or SAVE, the engine's ID field is compared with the group. A mismatch means no reset.
- R8: For LOAD, the NEXT_ID field is compared with the group instead of the ID field. A mismatch means no reset.
- R9: A matching engine is reset once the match has been seen on `poll_limit_i`+1 poll cycles. If the engine reads INVALID before that point, it is not reset.
- R10: Engines marked for reset are handled one at a time in ascending index order. For each one: `mem_halt_req_o` is held until acknowledged, then `eng_reset_o` is pulsed for one cycle, then `reinit_req_o` is held until acknowledged.
- R11: `done_o` is high for exactly one cycle, on the cycle after `sched_en_o`. `reset_mask_o` holds the set of engines reset and keeps it until the next start.
- R12: A start pulse received while a run is in progress is ignored. The group and runlist of the current run are unchanged.
- R13: An engine not marked in `eng_serves_i` is never reset, whatever its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| start_rl_i | input | RL_W | Runlist number for the run |
| start_gid_i | input | ID_W | Group ID to remove |
| poll_limit_i | input | TMO_W | Poll timeout limit for a matching engine |
| sched_dis_o | output | 1 | Scheduling disable pulse |
| sched_en_o | output | 1 | Scheduling enable pulse |
| sched_rl_o | output | RL_W | Runlist of the current run |
| chan_dis_o | output | 1 | Channel disable pulse for the group |
| preempt_o | output | 1 | Preempt request pulse |
| target_gid_o | output | ID_W | Group of the current run |
| pbdma_serves_i | input | NUM_PBDMA | PBDMAs serving the runlist |
| pbdma_busy_i | input | NUM_PBDMA | PBDMA channel status not yet invalid |
| pbdma_intr_i | input | NUM_PBDMA | PBDMA interrupt pending |
| intr_svc_req_o | output | NUM_PBDMA | Interrupt service request |
| intr_svc_ack_i | input | NUM_PBDMA | Interrupt service acknowledge |
| eng_serves_i | input | NUM_ENG | Engines serving the runlist |
| eng_ctx_st_i | input | 3*NUM_ENG | Per-engine context status |
| eng_id_i | input | ID_W*NUM_ENG | Per-engine current ID |
| eng_next_id_i | input | ID_W*NUM_ENG | Per-engine incoming ID |
| mem_halt_req_o | output | NUM_ENG | Memory-interface halt request |
| mem_halt_ack_i | input | NUM_ENG | Halt acknowledge |
| eng_reset_o | output | NUM_ENG | Engine reset enable pulse |
| reinit_req_o | output | NUM_ENG | Reinitialisation request |
| reinit_ack_i | input | NUM_ENG | Reinitialisation acknowledge |
| done_o | output | 1 | Run complete pulse |
| reset_mask_o | output | NUM_ENG | Engines reset in the last run |

## Verification
The assertions rely on two assumptions about the environment:

- `eng_serves_i` stays constant for the length of a run.
- An interrupt line drops once its acknowledge has been given, so that a request is never raised twice for one interrupt.

The bench holds the serve masks fixed from before the start pulse until done. Its interrupt model clears the pending line in the same cycle it acknowledges. Engine status changes are timed from the preempt pulse, and each delay is chosen well clear of the poll limit, so that every expected reset bit follows from the rules without depending on a one-cycle race.

// File: rtl/tds_pkg.sv
package tds_pkg;
    localparam int CTX_W = 3;

    typedef enum logic [CTX_W-1:0] {
        CTX_INVALID = 3'd0,
        CTX_VALID   = 3'd1,
        CTX_SAVE    = 3'd2,
        CTX_LOAD    = 3'd3,
        CTX_SWITCH  = 3'd4
    } ctx_st_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCHED_OFF,
        PH_CHAN_OFF,
        PH_PREEMPT,
        PH_POLL,
        PH_RESET,
        PH_SCHED_ON,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        RS_PICK,
        RS_HALT,
        RS_ASSERT,
        RS_REINIT
    } rst_step_e;
endpackage

// File: rtl/tds_eng_judge.sv
module tds_eng_judge
    import tds_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             poll_i,
    input  logic             serves_i,
    input  logic [CTX_W-1:0] st_i,
    input  logic [ID_W-1:0]  id_i,
    input  logic [ID_W-1:0]  nid_i,
    input  logic [ID_W-1:0]  gid_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             decided_o,
    output logic             reset_o
);
    typedef struct packed {
        logic             decided;
        logic             rst;
        logic [TMO_W-1:0] cnt;
    } judge_t;

    judge_t q, d;
    logic   owns;
    logic   match;

    always_comb begin
        d     = q;
        owns  = 1'b0;
        match = 1'b0;
        case (st_i)
            CTX_VALID, CTX_SAVE: begin
                owns  = 1'b1;
                match = (id_i == gid_i);
            end
            CTX_LOAD: begin
                owns  = 1'b1;
                match = (nid_i == gid_i);
            end
            default: ;
        endcase
        if (clr_i) begin
            d = '0;
        end else if (poll_i && !q.decided) begin
            if (!serves_i) begin
                d.decided = 1'b1;
            end else if (st_i == CTX_INVALID) begin
                d.decided = 1'b1;
            end else if (owns) begin
                if (!match) begin
                    d.decided = 1'b1;
                end else if (q.cnt >= limit_i) begin
                    d.decided = 1'b1;
                    d.rst     = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign decided_o = q.decided;
    assign reset_o   = q.rst;
endmodule

// File: rtl/tds_pbdma_watch.sv
module tds_pbdma_watch #(
    parameter int NUM_PBDMA = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 poll_i,
    input  logic [NUM_PBDMA-1:0] serves_i,
    input  logic [NUM_PBDMA-1:0] busy_i,
    input  logic [NUM_PBDMA-1:0] intr_i,
    input  logic [NUM_PBDMA-1:0] ack_i,
    output logic [NUM_PBDMA-1:0] req_o,
    output logic                 clean_o
);
    typedef struct packed {
        logic [NUM_PBDMA-1:0] req;
    } watch_t;

    watch_t q, d;

    always_comb begin
        d = q;
        for (int p = 0; p < NUM_PBDMA; p++) begin
            if (q.req[p]) begin
                if (ack_i[p]) d.req[p] = 1'b0;
            end else if (poll_i && serves_i[p] && intr_i[p]) begin
                d.req[p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o   = q.req;
    assign clean_o = poll_i && (&(~serves_i | ~(busy_i | intr_i | q.req)));
endmodule

// File: rtl/tds_reset_seq.sv
module tds_reset_seq
    import tds_pkg::*;
#(
    parameter int NUM_ENG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [NUM_ENG-1:0] mask_i,
    input  logic [NUM_ENG-1:0] halt_ack_i,
    input  logic [NUM_ENG-1:0] reinit_ack_i,
    output logic [NUM_ENG-1:0] halt_req_o,
    output logic [NUM_ENG-1:0] rst_o,
    output logic [NUM_ENG-1:0] reinit_req_o,
    output logic               finished_o
);
    localparam int IDX_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;

    typedef struct packed {
        logic               active;
        rst_step_e          step;
        logic [NUM_ENG-1:0] pend;
        logic [IDX_W-1:0]   idx;
    } seq_t;

    seq_t               q, d;
    logic [NUM_ENG-1:0] sel;

    always_comb begin
        d            = q;
        sel          = '0;
        sel[q.idx]   = 1'b1;
        halt_req_o   = '0;
        rst_o        = '0;
        reinit_req_o = '0;
        finished_o   = q.active && (q.step == RS_PICK) && (q.pend == '0);
        if (go_i) begin
            d.active = 1'b1;
            d.pend   = mask_i;
            d.step   = RS_PICK;
        end else if (q.active) begin
            case (q.step)
                RS_PICK: begin
                    if (q.pend == '0) begin
                        d.active = 1'b0;
                    end else begin
                        for (int i = NUM_ENG - 1; i >= 0; i--) begin
                            if (q.pend[i]) d.idx = IDX_W'(i);
                        end
                        d.pend[d.idx] = 1'b0;
                        d.step        = RS_HALT;
                    end
                end
                RS_HALT: begin
                    halt_req_o = sel;
                    if (|(halt_ack_i & sel)) d.step = RS_ASSERT;
                end
                RS_ASSERT: begin
                    rst_o  = sel;
                    d.step = RS_REINIT;
                end
                default: begin
                    reinit_req_o = sel;
                    if (|(reinit_ack_i & sel)) d.step = RS_PICK;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{active: 1'b0, step: RS_PICK, pend: '0, idx: '0};
        else        q <= d;
    end
endmodule

// File: rtl/tds_seq.sv
module tds_seq
    import tds_pkg::*;
#(
    parameter int NUM_PBDMA = 3,
    parameter int NUM_ENG   = 4,
    parameter int RL_W      = 3,
    parameter int ID_W      = 6,
    parameter int TMO_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [RL_W-1:0]          start_rl_i,
    input  logic [ID_W-1:0]          start_gid_i,
    input  logic [TMO_W-1:0]         poll_limit_i,
    output logic                     sched_dis_o,
    output logic                     sched_en_o,
    output logic [RL_W-1:0]          sched_rl_o,
    output logic                     chan_dis_o,
    output logic                     preempt_o,
    output logic [ID_W-1:0]          target_gid_o,
    input  logic [NUM_PBDMA-1:0]     pbdma_serves_i,
    input  logic [NUM_PBDMA-1:0]     pbdma_busy_i,
    input  logic [NUM_PBDMA-1:0]     pbdma_intr_i,
    output logic [NUM_PBDMA-1:0]     intr_svc_req_o,
    input  logic [NUM_PBDMA-1:0]     intr_svc_ack_i,
    input  logic [NUM_ENG-1:0]       eng_serves_i,
    input  logic [CTX_W*NUM_ENG-1:0] eng_ctx_st_i,
    input  logic [ID_W*NUM_ENG-1:0]  eng_id_i,
    input  logic [ID_W*NUM_ENG-1:0]  eng_next_id_i,
    output logic [NUM_ENG-1:0]       mem_halt_req_o,
    input  logic [NUM_ENG-1:0]       mem_halt_ack_i,
    output logic [NUM_ENG-1:0]       eng_reset_o,
    output logic [NUM_ENG-1:0]       reinit_req_o,
    input  logic [NUM_ENG-1:0]       reinit_ack_i,
    output logic                     done_o,
    output logic [NUM_ENG-1:0]       reset_mask_o
);
    typedef struct packed {
        phase_e             phase;
        logic [RL_W-1:0]    rl;
        logic [ID_W-1:0]    gid;
        logic [NUM_ENG-1:0] mask;
    } top_t;

    top_t               q, d;
    logic               accept;
    logic               polling;
    logic               go;
    logic               pb_clean;
    logic               seq_fin;
    logic [NUM_ENG-1:0] decided;
    logic [NUM_ENG-1:0] want_rst;

    assign accept  = (q.phase == PH_IDLE) && start_i;
    assign polling = (q.phase == PH_POLL);

    tds_pbdma_watch #(.NUM_PBDMA(NUM_PBDMA)) pb_watch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll_i  (polling),
        .serves_i(pbdma_serves_i),
        .busy_i  (pbdma_busy_i),
        .intr_i  (pbdma_intr_i),
        .ack_i   (intr_svc_ack_i),
        .req_o   (intr_svc_req_o),
        .clean_o (pb_clean)
    );

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_judge
        tds_eng_judge #(.ID_W(ID_W), .TMO_W(TMO_W)) judge_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (accept),
            .poll_i   (polling),
            .serves_i (eng_serves_i[e]),
            .st_i     (eng_ctx_st_i[e*CTX_W +: CTX_W]),
            .id_i     (eng_id_i[e*ID_W +: ID_W]),
            .nid_i    (eng_next_id_i[e*ID_W +: ID_W]),
            .gid_i    (q.gid),
            .limit_i  (poll_limit_i),
            .decided_o(decided[e]),
            .reset_o  (want_rst[e])
        );
    end

    tds_reset_seq #(.NUM_ENG(NUM_ENG)) rst_seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .mask_i      (want_rst),
        .halt_ack_i  (mem_halt_ack_i),
        .reinit_ack_i(reinit_ack_i),
        .halt_req_o  (mem_halt_req_o),
        .rst_o       (eng_reset_o),
        .reinit_req_o(reinit_req_o),
        .finished_o  (seq_fin)
    );

    always_comb begin
        d  = q;
        go = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.rl    = start_rl_i;
                    d.gid   = start_gid_i;
                    d.mask  = '0;
                    d.phase = PH_SCHED_OFF;
                end
            end
            PH_SCHED_OFF: d.phase = PH_CHAN_OFF;
            PH_CHAN_OFF:  d.phase = PH_PREEMPT;
            PH_PREEMPT:   d.phase = PH_POLL;
            PH_POLL: begin
                if (pb_clean && (&decided)) begin
                    go      = 1'b1;
                    d.mask  = want_rst;
                    d.phase = PH_RESET;
                end
            end
            PH_RESET: if (seq_fin) d.phase = PH_SCHED_ON;
            PH_SCHED_ON: d.phase = PH_DONE;
            default:     d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, rl: '0, gid: '0, mask: '0};
        else        q <= d;
    end

    assign sched_dis_o  = (q.phase == PH_SCHED_OFF);
    assign chan_dis_o   = (q.phase == PH_CHAN_OFF);
    assign preempt_o    = (q.phase == PH_PREEMPT);
    assign sched_en_o   = (q.phase == PH_SCHED_ON);
    assign done_o       = (q.phase == PH_DONE);
    assign sched_rl_o   = q.rl;
    assign target_gid_o = q.gid;
    assign reset_mask_o = q.mask;
endmodule

// File: rtl/tds_seq_chk.sv
module tds_seq_chk #(
    parameter int NUM_PBDMA = 3,
    parameter int NUM_ENG   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sched_dis_o,
    input logic                 chan_dis_o,
    input logic                 preempt_o,
    input logic                 sched_en_o,
    input logic                 done_o,
    input logic [NUM_ENG-1:0]   eng_serves_i,
    input logic [NUM_ENG-1:0]   mem_halt_req_o,
    input logic [NUM_ENG-1:0]   mem_halt_ack_i,
    input logic [NUM_ENG-1:0]   eng_reset_o,
    input logic [NUM_ENG-1:0]   reinit_req_o,
    input logic [NUM_PBDMA-1:0] intr_svc_req_o,
    input logic [NUM_PBDMA-1:0] intr_svc_ack_i
);
    AST_CHAN_AFTER_SCHED: assert property (@(posedge clk) disable iff (!rst_n)
        chan_dis_o |-> $past(sched_dis_o)); // R1
    AST_PREEMPT_AFTER_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> $past(chan_dis_o)); // R1
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sched_dis_o, chan_dis_o, preempt_o, sched_en_o, done_o})); // R1
    AST_INTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(intr_svc_req_o) & ~$past(intr_svc_ack_i) & ~intr_svc_req_o) == '0)); // R4
    AST_RST_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_reset_o != '0) |-> ($past(mem_halt_req_o & mem_halt_ack_i) == eng_reset_o)); // R10
    AST_REINIT_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|reinit_req_o) |-> ($past(eng_reset_o) == reinit_req_o)); // R10
    AST_ONE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_reset_o)); // R10
    AST_SERVED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_reset_o & ~eng_serves_i) == '0); // R13
    AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(sched_en_o)); // R11
endmodule

bind tds_seq tds_seq_chk #(.NUM_PBDMA(NUM_PBDMA), .NUM_ENG(NUM_ENG)) chk_i (.*);

// File: tb/tds_seq_tb_top.sv
module tds_seq_tb_top;
    localparam int NP = 3, NE = 4, RL_W = 3, ID_W = 6, TMO_W = 8;
    localparam logic [2:0] S_INV = 3'd0, S_VAL = 3'd1, S_SAV = 3'd2, S_LOD = 3'd3, S_SWI = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              start_i = 1'b0;
    logic [RL_W-1:0]   start_rl = '0;
    logic [ID_W-1:0]   start_gid = '0;
    logic [TMO_W-1:0]  limit = '0;
    logic              sched_dis, sched_en, chan_dis, preempt, done;
    logic [RL_W-1:0]   sched_rl;
    logic [ID_W-1:0]   tgid;
    logic [NP-1:0]     pb_serves = '0, pb_busy, pb_intr, isr_req;
    logic [NP-1:0]     isr_ack = '0;
    logic [NE-1:0]     en_serves = '0, halt_req, eng_rst, rein_req, rmask;
    logic [NE-1:0]     halt_ack = '0, rein_ack = '0;
    logic [3*NE-1:0]   st_vec;
    logic [ID_W*NE-1:0] id_vec, nid_vec;

    // configuration, written by the driver only
    logic [2:0]      e_early [NE];
    logic [2:0]      e_late  [NE];
    logic [ID_W-1:0] e_id    [NE];
    logic [ID_W-1:0] e_nid   [NE];
    int              e_delay [NE];
    int              p_hold  [NP];
    logic [NP-1:0]   p_intr = '0;
    logic [RL_W-1:0] cur_rl = '0;
    logic [ID_W-1:0] cur_gid = '0;
    int              min_en_t = -1;

    // model/monitor state, written by the monitor only
    logic            running = 1'b0;
    int              tcnt = 0;
    logic [NP-1:0]   intr_live = '0;
    int              ph = 0, last_e = -1, done_seen = 0;
    logic [NE-1:0]   halted = '0, got = '0;
    int              m_total = 0, m_bad = 0;
    int              f_total = 0, f_bad = 0;
    logic [NE-1:0]   expq [$];

    tds_seq #(.NUM_PBDMA(NP), .NUM_ENG(NE), .RL_W(RL_W), .ID_W(ID_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_rl_i(start_rl),
        .start_gid_i(start_gid), .poll_limit_i(limit), .sched_dis_o(sched_dis),
        .sched_en_o(sched_en), .sched_rl_o(sched_rl), .chan_dis_o(chan_dis),
        .preempt_o(preempt), .target_gid_o(tgid), .pbdma_serves_i(pb_serves),
        .pbdma_busy_i(pb_busy), .pbdma_intr_i(pb_intr), .intr_svc_req_o(isr_req),
        .intr_svc_ack_i(isr_ack), .eng_serves_i(en_serves), .eng_ctx_st_i(st_vec),
        .eng_id_i(id_vec), .eng_next_id_i(nid_vec), .mem_halt_req_o(halt_req),
        .mem_halt_ack_i(halt_ack), .eng_reset_o(eng_rst), .reinit_req_o(rein_req),
        .reinit_ack_i(rein_ack), .done_o(done), .reset_mask_o(rmask)
    );

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            st_vec[e*3 +: 3] = (running && e_delay[e] >= 0 && tcnt >= e_delay[e]) ? e_late[e] : e_early[e];
            id_vec[e*ID_W +: ID_W]  = e_id[e];
            nid_vec[e*ID_W +: ID_W] = e_nid[e];
        end
        for (int p = 0; p < NP; p++)
            pb_busy[p] = !(running && tcnt >= p_hold[p] && !intr_live[p]);
        pb_intr = intr_live;
    end

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        m_total++;
        if (!ok) begin
            m_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fchk(input bit ok, input string req, input int act, input int exp);
        f_total++;
        if (!ok) begin
            f_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor + environment model
    always @(negedge clk) begin
        if (rst_n) begin
            if (sched_dis) begin
                mchk(ph == 0, "R1 sched_dis first", ph, 0);
                mchk(sched_rl == cur_rl, "R1 runlist", sched_rl, cur_rl);
                ph = 1; halted = '0; got = '0; last_e = -1;
            end
            if (chan_dis) begin
                mchk(ph == 1, "R1 chan_dis second", ph, 1);
                ph = 2;
            end
            if (preempt) begin
                mchk(ph == 2, "R1 preempt third", ph, 2);
                mchk(tgid == cur_gid, "R1 group", tgid, cur_gid);
                ph = 3;
            end
            if (isr_req != '0) mchk(ph == 3, "R2 intr service after preempt", ph, 3);
            for (int e = 0; e < NE; e++) begin
                if (halt_req[e]) begin
                    mchk(ph == 3, "R2 halt after preempt", ph, 3);
                    halted[e] = 1'b1;
                end
                if (eng_rst[e]) begin
                    mchk(halted[e], "R10 halt before reset", 0, 1);
                    mchk(e > last_e, "R10 ascending order", e, last_e + 1);
                    last_e = e; got[e] = 1'b1;
                end
            end
            if (sched_en) begin
                mchk(ph == 3, "R11 sched_en after poll", ph, 3);
                mchk((pb_serves & (pb_busy | intr_live)) == '0, "R3 PBDMAs clear",
                     int'(pb_serves & (pb_busy | intr_live)), 0);
                if (min_en_t >= 0) mchk(tcnt > min_en_t, "R5 SWITCH keeps polling", tcnt, min_en_t + 1);
                ph = 4;
            end
            if (done) begin
                logic [NE-1:0] ex;
                mchk(ph == 4, "R11 done after sched_en", ph, 4);
                ex = (expq.size() > 0) ? expq.pop_front() : 'x;
                mchk(rmask == ex, "R6 R7 R8 R9 R13 reset mask", rmask, ex);
                mchk(got == ex, "R10 engines pulsed", got, ex);
                mchk(tgid == cur_gid, "R12 group kept", tgid, cur_gid);
                ph = 0; done_seen++; running = 1'b0;
            end
            // environment
            if (preempt) begin
                running = 1'b1; tcnt = 0; intr_live = p_intr & pb_serves;
            end else if (running) tcnt++;
            for (int p = 0; p < NP; p++) begin
                if (isr_req[p] && !isr_ack[p]) begin
                    isr_ack[p] = 1'b1; intr_live[p] = 1'b0;
                end else isr_ack[p] = 1'b0;
            end
            halt_ack = halt_req;
            rein_ack = rein_req;
        end
    end

    function automatic logic [NE-1:0] expect_mask();
        logic [NE-1:0] m = '0;
        for (int e = 0; e < NE; e++) begin
            logic [2:0] s = (e_early[e] == S_SWI) ? e_late[e] : e_early[e];
            bit hit;
            hit = (s == S_LOD) ? (e_nid[e] == cur_gid) :
                  ((s == S_VAL || s == S_SAV) ? (e_id[e] == cur_gid) : 1'b0);
            if (e_early[e] != S_SWI && e_delay[e] >= 0 && e_late[e] == S_INV) hit = 0;
            m[e] = en_serves[e] && hit;
        end
        return m;
    endfunction

    task automatic set_eng(input int e, input logic [2:0] a, input logic [2:0] b,
                           input int id, input int nid, input int dly);
        e_early[e] = a; e_late[e] = b; e_id[e] = ID_W'(id); e_nid[e] = ID_W'(nid); e_delay[e] = dly;
    endtask

    bit hung = 0;

    task automatic run_case(input int rl, input int gid, input int lim, input bit restart);
        int n0 = done_seen, cyc = 0;
        cur_rl = RL_W'(rl); cur_gid = ID_W'(gid); limit = TMO_W'(lim);
        expq.push_back(expect_mask());
        @(negedge clk);
        start_rl = cur_rl; start_gid = cur_gid; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (restart) begin
            repeat (4) @(negedge clk);
            start_gid = cur_gid + 1'b1; start_rl = cur_rl + 1'b1; start_i = 1'b1; // R12
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_seen == n0 && cyc < 5000) begin
            @(negedge clk); cyc++;
        end
        if (done_seen == n0) begin
            hung = 1;
            fchk(0, "watchdog", cyc, 0);
        end
        repeat (3) @(negedge clk);
        fchk(done_seen == n0 + 1, "R11 R12 single done", done_seen - n0, 1);
        fchk(done == 1'b0, "R11 done one cycle", done, 0);
        fchk(rmask == expect_mask(), "R11 mask held", rmask, expect_mask());
    endtask

    initial begin
        for (int e = 0; e < NE; e++) set_eng(e, S_INV, S_INV, 0, 0, -1);
        for (int p = 0; p < NP; p++) p_hold[p] = 0;
        repeat (3) @(negedge clk);
        fchk({sched_dis, chan_dis, preempt, sched_en, done} == '0, "R1 reset idle", 1, 0);
        fchk(isr_req == '0 && halt_req == '0 && eng_rst == '0 && rein_req == '0, "R10 reset idle", 1, 0);
        fchk(rmask == '0, "R11 reset mask", rmask, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // case 1: VALID match timeout, SAVE mismatch, INVALID, LOAD next match
        pb_serves = 3'b011; p_hold[0] = 2; p_hold[1] = 6; p_hold[2] = 400; p_intr = 3'b110;
        en_serves = 4'b1111;
        set_eng(0, S_VAL, S_VAL, 5, 0, -1);   // R7 R9
        set_eng(1, S_SAV, S_SAV, 7, 5, -1);   // R7 mismatch
        set_eng(2, S_INV, S_INV, 5, 5, -1);   // R6
        set_eng(3, S_LOD, S_LOD, 9, 5, -1);   // R8
        run_case(2, 5, 4, 0);

        // case 2: leave before limit, LOAD uses next id, SWITCH then match, SAVE match
        pb_serves = 3'b111; p_hold[2] = 30; p_intr = 3'b001;
        set_eng(0, S_VAL, S_INV, 12, 0, 3);   // R9
        set_eng(1, S_LOD, S_LOD, 12, 3, -1);  // R8
        set_eng(2, S_SWI, S_VAL, 12, 0, 6);   // R5
        set_eng(3, S_SAV, S_SAV, 12, 0, -1);  // R7
        run_case(5, 12, 20, 0);

        // case 3: SWITCH then INVALID, unserved matching engines, zero limit
        pb_serves = 3'b100; p_hold[2] = 1; p_intr = 3'b000; min_en_t = 12;
        en_serves = 4'b0010;
        set_eng(0, S_VAL, S_VAL, 33, 0, -1);  // R13
        set_eng(1, S_SWI, S_INV, 0, 0, 12);   // R5 R6
        set_eng(2, S_LOD, S_LOD, 0, 33, -1);  // R13
        set_eng(3, S_SAV, S_SAV, 33, 0, -1);  // R13
        run_case(1, 33, 0, 0);
        min_en_t = -1;

        // case 4: every engine resets, start while busy is ignored
        pb_serves = 3'b111; p_hold[0] = 5; p_hold[1] = 1; p_hold[2] = 3; p_intr = 3'b010;
        en_serves = 4'b1111;
        for (int e = 0; e < NE; e++) set_eng(e, S_VAL, S_VAL, 60, 0, -1);
        set_eng(2, S_LOD, S_LOD, 0, 60, -1);
        run_case(7, 60, 0, 1);                // R10 R12

        $display("test done: total=%0d bad=%0d", m_total + f_total, m_bad + f_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", m_total + f_total + 1, m_bad + f_bad + 1);
        $finish;
    end
endmodule